// File: doc/BRIEF.md
# Counted-Sign Multi-Operand Adder

This block adds a large set of signed partial terms in one combinational pass and registers the result. A typical use is the inner product of a convolution window. With 25 weight–activation pairs, each product arrives as three shifted partial terms, which gives 75 operands. The block then produces the sum that feeds the next accumulation level.

Each operand arrives as a fixed-width two's-complement field, with its sign bit at the top of the field. The fields enter a carry-save tree of full-adder rows. Each row takes three vectors and returns two, so every stage shrinks the vector count to about two-thirds. The tree stops when two vectors remain.

Operands are not sign-extended to the full output width. Instead, a population count of the operand sign bits is negated and placed above the field width as one extra vector. That vector joins the tree at the last compression step, and a carry-lookahead adder resolves the final pair. The result is the signed sum modulo 2^OUT_W and is held in an output register.

Top module: `negcount_moa`

## Requirements
- R1: One clock edge after `ops_i` is applied, `sum_o` equals the signed sum of all `N_OPS` operands, taken modulo 2^OUT_W (18 bits by default).
- R2: Operand j occupies `ops_i[j*OP_W +: OP_W]` and is an `OP_W`-bit (12-bit) two's-complement value. Every position carries equal weight, so a single nonzero operand at any position appears unchanged, sign-extended, in `sum_o`.
- R3: A negative operand counts by its two's-complement value, not by its unsigned field. A lone operand 0x800 gives 0x3F800, and 75 operands of 0xFFF give 0x3FFB5 (-75).
- R4: When the exact sum leaves the 18-bit range, `sum_o` wraps. All operands at 0x800 give 0x1A800, and all at 0x7FF give 0x257B5.
- R5: While `rst_ni` is low, `sum_o` is 0 whatever `ops_i` holds. An assertion of `rst_ni` between clock edges clears it at once.
- R6: `sum_o` changes only at a rising clock edge. A change on `ops_i` between edges leaves it untouched until the next edge.
- R7: Operand order has no effect: the same set of operands placed in another order gives the same `sum_o`.
- R8: The sign correction touches only bits `OP_W` and above. The low `OP_W` bits of `sum_o` equal the low bits of the plain unsigned sum of the fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the result register loads on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the result |
| ops_i | input | N_OPS*OP_W | Packed operand fields, operand j at bits j*OP_W and up |
| sum_o | output | OUT_W | Registered two's-complement sum of all operands |

## Verification
The bench drives sets in which every operand is negative. A design that dropped or mis-scaled the count correction would then be off by a multiple of 4096, while keeping the low twelve bits correct. Extreme sets at 0x800 and 0x7FF exercise wraparound, and a correction that saturated or used too few bits would show there. A lone operand is walked across every position with alternating signs, which exposes a tree stage that drops a leftover vector or loses the top carry. Reordered copies of a random set must give identical results. Mid-cycle input changes and an asynchronous reset check that the output register neither leaks combinational values nor waits for a clock to clear.

// File: rtl/negcount_moa_pkg.sv
package negcount_moa_pkg;

  // vectors left after one 3:2 compression row over n vectors
  function automatic int next_cnt(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  function automatic int cnt_at(input int n0, input int k);
    int n;
    n = n0;
    for (int i = 0; i < k; i++) n = next_cnt(n);
    return n;
  endfunction

  function automatic int num_stages(input int n0);
    int n;
    int s;
    n = n0;
    s = 0;
    for (int i = 0; i < 64; i++) begin
      if (n > 2) begin
        n = next_cnt(n);
        s++;
      end
    end
    return s;
  endfunction

  // start index of stage k in the flat vector pool
  function automatic int pool_off(input int n0, input int k);
    int o;
    o = 0;
    for (int i = 0; i < k; i++) o += cnt_at(n0, i);
    return o;
  endfunction

endpackage

// File: rtl/nc_fa.sv
module nc_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  logic ab_x;
  assign ab_x = a_i ^ b_i;
  assign s_o  = ab_x ^ c_i;
  assign co_o = (a_i & b_i) | (c_i & ab_x);
endmodule

// File: rtl/nc_csa_row.sv
module nc_csa_row #(
  parameter int W = 18
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);
  assign cry_o[0] = 1'b0;

  for (genvar j = 0; j < W; j++) begin : g_bit
    if (j < W - 1) begin : g_fa
      nc_fa u_fa (
        .a_i (a_i[j]),
        .b_i (b_i[j]),
        .c_i (c_i[j]),
        .s_o (sum_o[j]),
        .co_o(cry_o[j+1])
      );
    end else begin : g_top
      // carry out of the top column falls outside the modulus
      assign sum_o[j] = a_i[j] ^ b_i[j] ^ c_i[j];
    end
  end
endmodule

// File: rtl/nc_negcount.sv
module nc_negcount #(
  parameter int N_OPS = 75,
  parameter int OP_W  = 12,
  parameter int OUT_W = 18
) (
  input  logic [N_OPS-1:0] sgn_i,
  output logic [OUT_W-1:0] corr_o
);
  localparam int CW = $clog2(N_OPS + 1);

  logic [CW-1:0]    cnt;
  logic [OUT_W-1:0] cnt_ext;
  logic [OUT_W-1:0] cnt_neg;

  always_comb begin
    cnt = '0;
    for (int j = 0; j < N_OPS; j++) cnt = cnt + CW'(sgn_i[j]);
  end

  assign cnt_ext = {{(OUT_W - CW){1'b0}}, cnt};
  assign cnt_neg = ~cnt_ext + OUT_W'(1);
  // each sign extension equals -1 at weight 2^OP_W
  assign corr_o  = cnt_neg << OP_W;
endmodule

// File: rtl/nc_cla.sv
module nc_cla #(
  parameter int W  = 18,
  parameter int GW = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  localparam int NG = (W + GW - 1) / GW;

  logic [W-1:0]  p;
  logic [W-1:0]  c;
  logic [W-2:0]  g;
  logic [NG-1:0] cg;
  logic          gg;
  logic          gp;

  always_comb begin
    p  = a_i ^ b_i;
    g  = a_i[W-2:0] & b_i[W-2:0];
    cg = '0;
    gg = 1'b0;
    gp = 1'b0;
    for (int k = 1; k < NG; k++) begin
      gg = 1'b0;
      gp = 1'b1;
      for (int i = (k - 1) * GW; i < k * GW; i++) begin
        gg = g[i] | (p[i] & gg);
        gp = gp & p[i];
      end
      cg[k] = gg | (gp & cg[k-1]);
    end
    c    = '0;
    c[0] = cg[0];
    for (int i = 1; i < W; i++) begin
      if (i % GW == 0) c[i] = cg[i/GW];
      else             c[i] = g[i-1] | (p[i-1] & c[i-1]);
    end
  end

  assign s_o = p ^ c;
endmodule

// File: rtl/nc_tree.sv
module nc_tree
  import negcount_moa_pkg::*;
#(
  parameter int N_OPS = 75,
  parameter int OP_W  = 12,
  parameter int OUT_W = 18
) (
  input  logic [N_OPS*OP_W-1:0] ops_i,
  input  logic [OUT_W-1:0]      corr_i,
  output logic [OUT_W-1:0]      sum_o
);
  localparam int NSTG   = num_stages(N_OPS);
  localparam int POOL_N = pool_off(N_OPS, NSTG + 1);
  localparam int LAST_B = pool_off(N_OPS, NSTG);
  localparam int NRED   = cnt_at(N_OPS, NSTG);

  logic [OUT_W-1:0] pool [POOL_N];
  logic [OUT_W-1:0] fin_b;
  logic [OUT_W-1:0] fin_s;
  logic [OUT_W-1:0] fin_c;

  // fields enter zero-extended; the correction vector owns the upper bits
  for (genvar j = 0; j < N_OPS; j++) begin : g_in
    assign pool[j] = {{(OUT_W - OP_W){1'b0}}, ops_i[j*OP_W +: OP_W]};
  end

  for (genvar k = 1; k <= NSTG; k++) begin : g_stg
    localparam int NP = cnt_at(N_OPS, k - 1);
    localparam int IB = pool_off(N_OPS, k - 1);
    localparam int OB = pool_off(N_OPS, k);
    localparam int NG = NP / 3;
    localparam int NR = NP % 3;

    for (genvar gi = 0; gi < NG; gi++) begin : g_row
      nc_csa_row #(.W(OUT_W)) u_row (
        .a_i  (pool[IB + 3*gi]),
        .b_i  (pool[IB + 3*gi + 1]),
        .c_i  (pool[IB + 3*gi + 2]),
        .sum_o(pool[OB + 2*gi]),
        .cry_o(pool[OB + 2*gi + 1])
      );
    end
    for (genvar r = 0; r < NR; r++) begin : g_pass
      assign pool[OB + 2*NG + r] = pool[IB + 3*NG + r];
    end
  end

  if (NRED > 1) begin : g_two
    assign fin_b = pool[LAST_B + 1];
  end else begin : g_one
    assign fin_b = '0;
  end

  // correction is ready late, so it joins only at the last compression
  nc_csa_row #(.W(OUT_W)) u_fin (
    .a_i  (pool[LAST_B]),
    .b_i  (fin_b),
    .c_i  (corr_i),
    .sum_o(fin_s),
    .cry_o(fin_c)
  );

  nc_cla #(.W(OUT_W), .GW(4)) u_cla (
    .a_i(fin_s),
    .b_i(fin_c),
    .s_o(sum_o)
  );
endmodule

// File: rtl/negcount_moa.sv
module negcount_moa #(
  parameter int N_OPS = 75,
  parameter int OP_W  = 12,
  parameter int OUT_W = 18
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_OPS*OP_W-1:0] ops_i,
  output logic [OUT_W-1:0]      sum_o
);
  logic [N_OPS-1:0] sgn_w;
  logic [OUT_W-1:0] corr_w;
  logic [OUT_W-1:0] sum_w;
  logic [OUT_W-1:0] sum_q;

  for (genvar j = 0; j < N_OPS; j++) begin : g_sgn
    assign sgn_w[j] = ops_i[j*OP_W + OP_W - 1];
  end

  nc_negcount #(.N_OPS(N_OPS), .OP_W(OP_W), .OUT_W(OUT_W)) u_neg (
    .sgn_i (sgn_w),
    .corr_o(corr_w)
  );

  nc_tree #(.N_OPS(N_OPS), .OP_W(OP_W), .OUT_W(OUT_W)) u_tree (
    .ops_i (ops_i),
    .corr_i(corr_w),
    .sum_o (sum_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= sum_w;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/negcount_moa_chk.sv
module negcount_moa_chk #(
  parameter int N_OPS = 75,
  parameter int OP_W  = 12,
  parameter int OUT_W = 18
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [N_OPS*OP_W-1:0] ops_i,
  input logic [OUT_W-1:0]      sum_o,
  input logic [OUT_W-1:0]      corr_i
);
  function automatic logic [OUT_W-1:0] ref_sum(input logic [N_OPS*OP_W-1:0] v);
    longint s;
    s = 0;
    for (int j = 0; j < N_OPS; j++) s += longint'($signed(v[j*OP_W +: OP_W]));
    return OUT_W'(s);
  endfunction

  function automatic logic any_neg(input logic [N_OPS*OP_W-1:0] v);
    logic f;
    f = 1'b0;
    for (int j = 0; j < N_OPS; j++) f = f | v[j*OP_W + OP_W - 1];
    return f;
  endfunction

  AST_SUM_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sum_o == ref_sum($past(ops_i))); // R1

  AST_ZERO_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ops_i == '0 |=> sum_o == '0); // R2

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $stable(ops_i)) |=> $stable(sum_o)); // R6

  AST_CORR_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_neg(ops_i) |-> corr_i == '0); // R3

  AST_CORR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_i[OP_W-1:0] == '0); // R8
endmodule

bind negcount_moa negcount_moa_chk #(.N_OPS(N_OPS), .OP_W(OP_W), .OUT_W(OUT_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .ops_i (ops_i),
  .sum_o (sum_o),
  .corr_i(corr_w)
);

// File: tb/negcount_moa_test.sv
`timescale 1ns/1ps
module negcount_moa_test;
  localparam int N  = 75;
  localparam int W  = 12;
  localparam int OW = 18;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N*W-1:0]  ops_i = '0;
  logic [OW-1:0]   sum_o;

  int n_chk = 0;
  int n_err = 0;
  logic [OW-1:0] exp_q [$];
  string         tag_q [$];

  negcount_moa #(.N_OPS(N), .OP_W(W), .OUT_W(OW)) uut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ops_i (ops_i),
    .sum_o (sum_o)
  );

  always #2.5 clk_i = ~clk_i;

  function automatic logic [OW-1:0] model(input logic [N*W-1:0] v);
    longint s;
    s = 0;
    for (int j = 0; j < N; j++) s += longint'($signed(v[j*W +: W]));
    return OW'(s);
  endfunction

  function automatic logic [W-1:0] fld_sum(input logic [N*W-1:0] v);
    int s;
    s = 0;
    for (int j = 0; j < N; j++) s += int'(v[j*W +: W]);
    return W'(s);
  endfunction

  function automatic logic [N*W-1:0] fill(input logic [W-1:0] f);
    logic [N*W-1:0] v;
    for (int j = 0; j < N; j++) v[j*W +: W] = f;
    return v;
  endfunction

  task automatic check(input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // compare the output loaded last edge, then apply the next set
  task automatic step(input logic [N*W-1:0] v, input string tag);
    @(negedge clk_i);
    if (exp_q.size() > 0) check(tag_q.pop_front(), sum_o, exp_q.pop_front());
    ops_i = v;
    exp_q.push_back(model(v));
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    step('0, "R1 zero set");
    @(negedge clk_i);
    check(tag_q.pop_front(), sum_o, exp_q.pop_front());
  endtask

  initial begin
    #(5.0 * 200000);
    n_err++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [N*W-1:0] v;
    logic [N*W-1:0] rv;
    logic [OW-1:0]  held;

    // R5: reset holds zero with busy inputs
    ops_i = fill(12'h7FF);
    repeat (3) begin
      @(negedge clk_i);
      check("R5 in reset", sum_o, '0);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2: one operand walked over every position, alternating sign
    for (int j = 0; j < N; j++) begin
      v = '0;
      v[j*W +: W] = (j % 2 == 0) ? 12'h7FF : 12'h800;
      step(v, "R2 single position");
    end
    drain();

    // R3 fixed points
    v = '0;
    v[0 +: W] = 12'h800;
    step(v, "R3 lone 0x800");
    step(fill(12'hFFF), "R3 all minus one");
    @(negedge clk_i);
    check(tag_q.pop_front(), sum_o, exp_q.pop_front());
    check("R3 lone 0x800 value", model(v), 18'h3F800);
    check("R3 all minus one value", sum_o, 18'h3FFB5);
    ops_i = '0;
    exp_q.delete();
    tag_q.delete();

    // R4 wrap at both extremes
    step(fill(12'h800), "R4 all 0x800");
    @(negedge clk_i);
    check("R4 all 0x800", sum_o, 18'h1A800);
    ops_i = fill(12'h7FF);
    exp_q.delete();
    tag_q.delete();
    @(negedge clk_i);
    check("R4 all 0x7FF", sum_o, 18'h257B5);

    // R1 random full-range sets
    for (int t = 0; t < 40; t++) begin
      for (int j = 0; j < N; j++) v[j*W +: W] = W'($urandom);
      step(v, "R1 random");
    end
    // R1 all-positive and R8 all-negative random sets
    for (int t = 0; t < 20; t++) begin
      for (int j = 0; j < N; j++) v[j*W +: W] = {1'b0, 11'($urandom)};
      step(v, "R1 all positive");
    end
    drain();
    for (int t = 0; t < 20; t++) begin
      for (int j = 0; j < N; j++) v[j*W +: W] = {1'b1, 11'($urandom)};
      step(v, "R8 all negative");
      @(negedge clk_i);
      check(tag_q.pop_front(), sum_o, exp_q.pop_front());
      check("R8 low bits", {{(OW-W){1'b0}}, sum_o[W-1:0]}, {{(OW-W){1'b0}}, fld_sum(v)});
    end

    // R7 same set reversed and rotated
    for (int j = 0; j < N; j++) v[j*W +: W] = W'($urandom);
    for (int j = 0; j < N; j++) rv[j*W +: W] = v[(N-1-j)*W +: W];
    step(v, "R7 original order");
    step(rv, "R7 reversed order");
    step({v[W-1:0], v[N*W-1:W]}, "R7 rotated order");
    drain();
    check("R7 reorder model", model(rv), model(v));

    // R6 mid-cycle change must wait for the edge
    v = fill(12'h123);
    step(v, "R6 setup");
    @(negedge clk_i);
    check(tag_q.pop_front(), sum_o, exp_q.pop_front());
    held = sum_o;
    ops_i = fill(12'hABC);
    #1;
    check("R6 hold between edges", sum_o, held);
    @(negedge clk_i);
    check("R6 update after edge", sum_o, model(fill(12'hABC)));

    // R5 asynchronous clear between edges
    #1;
    rst_ni = 1'b0;
    #0.5;
    check("R5 async clear", sum_o, '0);
    @(negedge clk_i);
    check("R5 held in reset", sum_o, '0);
    rst_ni = 1'b1;
    step(fill(12'h001), "R1 after reset");
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule